// File: doc/BRIEF.md
# Nibble-wide serial pseudo-static RAM controller with divided memory clock

The controller runs one transaction at a time against a 4-bit serial pseudo-static RAM from a fast system clock. The memory clock is derived from the system clock. Its ratio is two, three or four system clocks per memory clock, and the ratio is chosen when each request starts. A transaction lowers chip select and clocks out a 32-bit header of command and address as eight nibbles. For a write it then streams the data bytes. For a read it releases the bus, lets the device's fixed latency pass, and captures the returned nibbles on a system-clock grid. The start of that grid is set by a delay in system clocks that absorbs pin-register and board delay.

The user side is a request port with command, address, byte count and a start strobe. Write bytes are pulled through a take strobe. Read bytes come out with a valid strobe. After chip select rises the block holds it high for a minimum time set by parameters, then pulses `done`. `busy` covers the whole span from start to done.

Top module: `qpr_ctrl`

## Requirements
- R1: During and right after reset, `pram_cs_n` is 1, `pram_sck` is 0, `pram_dq_oe` is 0, and `busy` and `done` are 0.
- R2: Each transaction first sends the 32-bit word {req_cmd[7:0], req_addr[23:0]} as eight nibbles, most significant nibble first. Each nibble is driven with `pram_dq_oe` high and is valid at the rising edge of `pram_sck` in its memory cycle.
- R3: `cfg_div` is sampled at start. Code 01 gives 3 system clocks per memory clock, code 10 gives 4, and codes 00 and 11 give 2. Counting from the first system cycle of a memory cycle as phase 0, the clock rises at phase 1 for ratio 2, at phase 2 for ratio 3 (high for one cycle, low for two) and at phase 1 for ratio 4 (high for two cycles).
- R4: A write sends its data bytes right after the header, high nibble first, one nibble per memory cycle. `wr_take` is high in the cycle in which `wr_data` is sampled, once per byte. Chip select stays low for exactly (9+2N) × ratio system cycles, where N is the byte count.
- R5: A read stops driving the bus from memory cycle 8 until chip select rises. It then issues 5 wait memory clocks and 2N data memory clocks, so there are 13+2N rising edges in total.
- R6: Counting from the first cycle with chip select low as cycle 0, read nibble k is the value of `pram_dq_i` in cycle (13+k) × ratio + `cfg_delay`. Pairs of nibbles are packed high nibble first and output with a one-cycle `rd_valid`.
- R7: On a read, chip select stays low for max((14+2N) × ratio, (12+2N) × ratio + `cfg_delay` + 2) cycles. This covers at least one memory period after the last clock and everything up to the last capture.
- R8: `pram_sck` is never high while `pram_cs_n` is high.
- R9: `busy` rises in the cycle after an accepted start. Chip select then stays high for CSH_CYC cycles, which is the 18 ns gap rounded up to system clocks. `done` pulses for one cycle after that, and `busy` is low in the same cycle.
- R10: A start, a `cfg_div` change or a `cfg_delay` change that arrives while `busy` is high has no effect on the transaction in progress and starts no new one.
- R11: The byte count N is `req_len` + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_div | input | 2 | Clock ratio code, sampled at start |
| cfg_delay | input | DLY_W | Read capture delay in system clocks, sampled at start |
| req_start | input | 1 | Start strobe, accepted only while idle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_cmd | input | CMD_W | Command byte |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | LEN_W | Byte count minus one |
| wr_data | input | 8 | Next write byte |
| wr_take | output | 1 | `wr_data` is sampled this cycle |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| pram_cs_n | output | 1 | Memory chip select, active low |
| pram_sck | output | 1 | Memory clock |
| pram_dq_o | output | 4 | Bus output nibble |
| pram_dq_oe | output | 1 | Bus output enable |
| pram_dq_i | input | 4 | Bus input nibble |

## Verification
If the phase counter slips, the rising edges move off their phase and the edge count changes. This shows on the first header nibble. A wrong nibble or memory-cycle count changes the decoded header, the write bytes or the chip-select low length within one transaction. A capture-delay error moves the sample point out of the bench's data window and corrupts the first read byte. An error in the gap counter moves `done` relative to the rise of chip select.

// File: rtl/qpr_pkg.sv
// Shared types and decode helpers for the nibble-bus RAM controller.
// Assumes the ratio is one of 2, 3 or 4 and the phase fits in two bits.
package qpr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CMD  = 3'd1,
        ST_WAIT = 3'd2,
        ST_XFER = 3'd3,
        ST_TAIL = 3'd4,
        ST_GAP  = 3'd5
    } qpr_state_e;

    // Maps the ratio code to system clocks per memory clock.
    function automatic logic [2:0] qpr_div_decode(input logic [1:0] code);
        case (code)
            2'b01:   return 3'd3;
            2'b10:   return 3'd4;
            default: return 3'd2;
        endcase
    endfunction

    // Memory clock level for a given phase and ratio.
    function automatic logic qpr_sck_level(input logic [1:0] ph, input logic [2:0] div);
        case (div)
            3'd3:    return (ph == 2'd2);
            3'd4:    return (ph == 2'd1) || (ph == 2'd2);
            default: return (ph == 2'd1);
        endcase
    endfunction

endpackage

// File: rtl/qpr_clkgen.sv
// Memory clock generator: a phase counter over the chosen ratio and a
// registered clock output. Phase 0 is the first system cycle of a memory cycle.
// Assumes div stays constant while run is high.
module qpr_clkgen
    import qpr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] div,
    output logic       sck,
    output logic       tick
);

    logic [1:0] ph;

    // Last system cycle of the current memory cycle.
    assign tick = run && ({1'b0, ph} == (div - 3'd1));

    // Advance the phase and register the clock level of the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= 2'd0;
            sck <= 1'b0;
        end else if (run && !tick) begin
            ph  <= ph + 2'd1;
            sck <= qpr_sck_level(ph + 2'd1, div);
        end else begin
            ph  <= 2'd0;
            sck <= 1'b0;
        end
    end

    AST_HIGH_ONE_AT_3: assert property (@(posedge clk) disable iff (!rst_n)
        (div == 3'd3) && $rose(sck) |=> !sck);   // R3
    AST_HIGH_TWO_AT_4: assert property (@(posedge clk) disable iff (!rst_n)
        (div == 3'd4) && $rose(sck) |=> sck);    // R3

endmodule

// File: rtl/qpr_rxcap.sv
// Read capture: waits 'delay' system clocks after arm, then samples one nibble
// every 'div' clocks until last+1 nibbles are in, packing them high nibble first.
// Assumes arm comes only while idle.
module qpr_rxcap #(
    parameter int NIB_W = 5,
    parameter int DLY_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [DLY_W-1:0] delay,
    input  logic [2:0]       div,
    input  logic [NIB_W-1:0] last,
    input  logic [3:0]       dq_i,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             idle
);

    logic             act;
    logic [DLY_W-1:0] dcnt;
    logic [1:0]       sp;
    logic [NIB_W-1:0] nib;
    logic [3:0]       hi_nib;

    assign idle = !act;

    // Delay countdown, then sampling on the ratio grid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act      <= 1'b0;
            dcnt     <= '0;
            sp       <= 2'd0;
            nib      <= '0;
            hi_nib   <= 4'd0;
            rd_data  <= 8'd0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (arm) begin
                act  <= 1'b1;
                dcnt <= delay;
                sp   <= 2'd0;
                nib  <= '0;
            end else if (act) begin
                if (dcnt != '0) begin
                    dcnt <= dcnt - 1'b1;
                end else begin
                    if (sp == 2'd0) begin
                        if (!nib[0]) begin
                            hi_nib <= dq_i;
                        end else begin
                            rd_data  <= {hi_nib, dq_i};
                            rd_valid <= 1'b1;
                        end
                        if (nib == last) act <= 1'b0;
                        nib <= nib + 1'b1;
                    end
                    sp <= ({1'b0, sp} == (div - 3'd1)) ? 2'd0 : sp + 2'd1;
                end
            end
        end
    end

    AST_ARM_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> !act);   // R6

endmodule

// File: rtl/qpr_ctrl.sv
// Top of the nibble-bus RAM controller: request sequencer, header and write
// shifter, chip-select hold and gap. Assumes CMD_W+ADDR_W is a multiple of 4
// and the device needs WAIT_MC memory clocks of read latency.
module qpr_ctrl
    import qpr_pkg::*;
#(
    parameter int CMD_W     = 8,
    parameter int ADDR_W    = 24,
    parameter int LEN_W     = 4,
    parameter int DLY_W     = 5,
    parameter int WAIT_MC   = 5,
    parameter int SYS_NS    = 20,
    parameter int CS_GAP_NS = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_div,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic              req_start,
    input  logic              req_write,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        wr_data,
    output logic              wr_take,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              done,
    output logic              pram_cs_n,
    output logic              pram_sck,
    output logic [3:0]        pram_dq_o,
    output logic              pram_dq_oe,
    input  logic [3:0]        pram_dq_i
);

    localparam int HDR_W   = CMD_W + ADDR_W;
    localparam int HDR_NIB = HDR_W / 4;
    localparam int NIB_W   = LEN_W + 1;
    localparam int MC_W    = ((NIB_W > 4) ? NIB_W : 4) + 1;
    localparam int CSH_RAW = (CS_GAP_NS + SYS_NS - 1) / SYS_NS;
    localparam int CSH_CYC = (CSH_RAW < 1) ? 1 : CSH_RAW;
    localparam int CNT_W   = $clog2(CSH_CYC + 5) + 1;

    qpr_state_e       state;
    logic [2:0]       div_q;
    logic [DLY_W-1:0] dly_q;
    logic             wr_q;
    logic [LEN_W-1:0] len_q;
    logic [MC_W-1:0]  mcnt;
    logic [CNT_W-1:0] cnt;
    logic [HDR_W-1:0] sh;
    logic             run, tick, arm, rx_idle;
    logic [MC_W-1:0]  last_nib;
    logic [CNT_W-1:0] hi_run;

    assign run       = (state == ST_CMD) || (state == ST_WAIT) || (state == ST_XFER);
    assign last_nib  = MC_W'({len_q, 1'b1});
    assign arm       = (state == ST_WAIT) && tick && (mcnt == MC_W'(WAIT_MC - 1));
    assign pram_dq_o = sh[HDR_W-1 -: 4];
    assign busy      = (state != ST_IDLE);
    assign wr_take   = wr_q && tick &&
                       (((state == ST_CMD) && (mcnt == MC_W'(HDR_NIB - 1))) ||
                        ((state == ST_XFER) && mcnt[0] && (mcnt != last_nib)));

    qpr_clkgen u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div_q),
        .sck   (pram_sck),
        .tick  (tick)
    );

    qpr_rxcap #(.NIB_W(NIB_W), .DLY_W(DLY_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .delay    (dly_q),
        .div      (div_q),
        .last     (NIB_W'({len_q, 1'b1})),
        .dq_i     (pram_dq_i),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .idle     (rx_idle)
    );

    // Transaction sequencer: header, wait, data, hold, gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            div_q      <= 3'd2;
            dly_q      <= '0;
            wr_q       <= 1'b0;
            len_q      <= '0;
            mcnt       <= '0;
            cnt        <= '0;
            sh         <= '0;
            pram_cs_n  <= 1'b1;
            pram_dq_oe <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (req_start) begin
                    state      <= ST_CMD;
                    pram_cs_n  <= 1'b0;
                    pram_dq_oe <= 1'b1;
                    sh         <= {req_cmd, req_addr};
                    div_q      <= qpr_div_decode(cfg_div);
                    dly_q      <= cfg_delay;
                    wr_q       <= req_write;
                    len_q      <= req_len;
                    mcnt       <= '0;
                end
                ST_CMD: if (tick) begin
                    if (mcnt == MC_W'(HDR_NIB - 1)) begin
                        mcnt <= '0;
                        if (wr_q) begin
                            state             <= ST_XFER;
                            sh[HDR_W-1 -: 8]  <= wr_data;
                        end else begin
                            state      <= ST_WAIT;
                            pram_dq_oe <= 1'b0;
                        end
                    end else begin
                        mcnt <= mcnt + 1'b1;
                        sh   <= sh << 4;
                    end
                end
                ST_WAIT: if (tick) begin
                    if (mcnt == MC_W'(WAIT_MC - 1)) begin
                        state <= ST_XFER;
                        mcnt  <= '0;
                    end else begin
                        mcnt <= mcnt + 1'b1;
                    end
                end
                ST_XFER: if (tick) begin
                    if (mcnt == last_nib) begin
                        state      <= ST_TAIL;
                        pram_dq_oe <= 1'b0;
                        cnt        <= '0;
                    end else begin
                        mcnt <= mcnt + 1'b1;
                        if (mcnt[0]) sh[HDR_W-1 -: 8] <= wr_data;
                        else         sh <= sh << 4;
                    end
                end
                ST_TAIL: begin
                    if ((cnt >= CNT_W'(div_q - 3'd1)) && (wr_q || rx_idle)) begin
                        state     <= ST_GAP;
                        pram_cs_n <= 1'b1;
                        cnt       <= '0;
                    end else if (cnt < CNT_W'(div_q - 3'd1)) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cnt == CNT_W'(CSH_CYC - 1)) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Count of chip-select high cycles, saturating, for the gap check.
    always_ff @(posedge clk) begin
        if (!rst_n)                         hi_run <= CNT_W'(CSH_CYC);
        else if (!pram_cs_n)                hi_run <= '0;
        else if (hi_run < CNT_W'(CSH_CYC))  hi_run <= hi_run + 1'b1;
    end

    AST_NO_CLK_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        pram_cs_n |-> !pram_sck);                        // R8
    AST_BUS_FLOAT_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !pram_dq_oe);             // R5
    AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pram_cs_n) |-> (hi_run >= CNT_W'(CSH_CYC))); // R9
    AST_CAPTURE_BEFORE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pram_cs_n) |-> rx_idle);                   // R7

endmodule

// File: tb/qpr_ctrl_bench.sv
module qpr_ctrl_bench;

    localparam int LAT = 2;
    localparam int CSH = (18 + 20 - 1) / 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_div;
    logic [4:0] cfg_delay;
    logic       req_start, req_write;
    logic [7:0] req_cmd;
    logic [23:0] req_addr;
    logic [3:0] req_len;
    logic [7:0] wr_data;
    logic       wr_take, rd_valid, busy, done;
    logic [7:0] rd_data;
    logic       pram_cs_n, pram_sck, pram_dq_oe;
    logic [3:0] pram_dq_o;
    logic [3:0] pram_dq_i;

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // monitor state
    int j = 0, low_len = 0, hcnt = 0, done_h = -1, falls = 0;
    int rise_cnt = 0, phase_err = 0, oe_err = 0, nib_n = 0, rd_n = 0;
    int sck_cs_err = 0, widx = 0;
    bit take_seen = 0, cs_p = 1, sck_p = 0;
    logic [3:0] nibs [0:31];
    logic [7:0] rd_bytes [0:7];
    int m_div = 2, m_nnib = 2;
    bit m_wr = 0;
    logic [3:0] m_base = 4'd0;
    logic [7:0] m_seed = 8'd0;

    function automatic logic [7:0] wbyte(input int b, input logic [7:0] seed);
        return seed ^ 8'(b * 71 + 17);
    endfunction

    function automatic logic [3:0] rnib(input int k, input logic [3:0] base);
        return 4'(int'(base) + 3 * k);
    endfunction

    assign wr_data = wbyte(widx, m_seed);

    qpr_ctrl u_qpr_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_delay(cfg_delay),
        .req_start(req_start), .req_write(req_write), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data),
        .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .done(done), .pram_cs_n(pram_cs_n), .pram_sck(pram_sck),
        .pram_dq_o(pram_dq_o), .pram_dq_oe(pram_dq_oe), .pram_dq_i(pram_dq_i)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model and port monitor, away from the active edge.
    always @(negedge clk) begin
        if (!pram_cs_n) begin
            if (cs_p) begin j = 0; falls++; end else j++;
            low_len = j + 1;
            if (pram_sck && !sck_p) begin
                rise_cnt++;
                if ((j % m_div) != ((m_div == 3) ? 2 : 1)) phase_err++;
                if (pram_dq_oe && nib_n < 32) begin nibs[nib_n] = pram_dq_o; nib_n++; end
            end
            if (!m_wr && j >= 8 * m_div && pram_dq_oe) oe_err++;
            if (j >= 13 * m_div + LAT && (j - 13 * m_div - LAT) / m_div < m_nnib)
                pram_dq_i = rnib((j - 13 * m_div - LAT) / m_div, m_base);
            else
                pram_dq_i = m_base + 4'd8;
        end else begin
            if (!cs_p) hcnt = 0; else hcnt++;
            pram_dq_i = m_base + 4'd8;
            if (pram_sck) sck_cs_err++;
        end
        if (done) done_h = hcnt;
        if (rd_valid && rd_n < 8) begin rd_bytes[rd_n] = rd_data; rd_n++; end
        if (take_seen) widx++;
        take_seen = wr_take;
        cs_p = pram_cs_n;
        sck_p = pram_sck;
    end

    task automatic run_req(input bit wr, input logic [7:0] cmd, input logic [23:0] addr,
                           input int len, input int code, input int dly, input bit poke);
        int n, tmo, mism, explow;
        logic [31:0] hdr;
        bit inwin;
        @(negedge clk);
        nib_n = 0; rise_cnt = 0; phase_err = 0; oe_err = 0; rd_n = 0;
        widx = 0; take_seen = 0; falls = 0; done_h = -1;
        m_div = (code == 1) ? 3 : (code == 2) ? 4 : 2;
        m_wr = wr; m_base = addr[3:0]; m_nnib = 2 * (len + 1); m_seed = cmd;
        cfg_div = 2'(code); cfg_delay = 5'(dly);
        req_write = wr; req_cmd = cmd; req_addr = addr; req_len = 4'(len);
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        check(busy == 1'b1, "R9 busy after start", busy, 1);
        if (poke) begin
            repeat (4) @(negedge clk);
            req_cmd = ~cmd; cfg_div = 2'(code + 1); cfg_delay = 5'(dly + 3);
            req_start = 1'b1;
            @(negedge clk);
            req_start = 1'b0;
        end
        tmo = 0;
        while (!done && tmo < 5000) begin @(negedge clk); tmo++; end
        check(done == 1'b1 && busy == 1'b0, "R9 done with busy low", {done, busy}, 2'b10);
        @(negedge clk);
        check(done_h == CSH, "R9 chip-select gap before done", done_h, CSH);
        n = len + 1;
        hdr = {nibs[0], nibs[1], nibs[2], nibs[3], nibs[4], nibs[5], nibs[6], nibs[7]};
        check(hdr == {cmd, addr}, "R2 header word", hdr, {cmd, addr});
        check(phase_err == 0, "R3 rising edge phase", phase_err, 0);
        check(sck_cs_err == 0, "R8 clock while deselected", sck_cs_err, 0);
        check(falls == 1, "R10 one chip-select period", falls, 1);
        if (wr) begin
            check(nib_n == 8 + 2 * n, "R11 write nibble count", nib_n, 8 + 2 * n);
            mism = 0;
            for (int b = 0; b < n; b++)
                if ({nibs[8 + 2 * b], nibs[9 + 2 * b]} != wbyte(b, cmd)) mism++;
            check(mism == 0, "R4 write bytes", mism, 0);
            check(low_len == (9 + 2 * n) * m_div, "R4 write select length", low_len, (9 + 2 * n) * m_div);
        end else begin
            check(nib_n == 8, "R5 only header driven", nib_n, 8);
            check(oe_err == 0, "R5 bus released", oe_err, 0);
            check(rise_cnt == 13 + 2 * n, "R5 read clock count", rise_cnt, 13 + 2 * n);
            check(rd_n == n, "R11 read byte count", rd_n, n);
            mism = 0;
            for (int b = 0; b < n; b++)
                if (rd_bytes[b] != {rnib(2 * b, addr[3:0]), rnib(2 * b + 1, addr[3:0])}) mism++;
            inwin = (dly >= LAT) && (dly <= LAT + m_div - 1);
            if (inwin) begin
                check(mism == 0, "R6 capture in window", mism, 0);
                explow = (14 + 2 * n) * m_div;
                if ((12 + 2 * n) * m_div + dly + 2 > explow) explow = (12 + 2 * n) * m_div + dly + 2;
                check(low_len == explow, "R7 read select length", low_len, explow);
            end else begin
                check(mism > 0, "R6 capture outside window", mism, 1);
            end
        end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_div = 2'd0; cfg_delay = 5'd0; req_start = 1'b0;
        req_write = 1'b0; req_cmd = 8'd0; req_addr = 24'd0; req_len = 4'd0;
        pram_dq_i = 4'd0;
        repeat (5) @(negedge clk);
        check(pram_cs_n && !pram_sck && !pram_dq_oe && !busy && !done,
              "R1 reset outputs", {pram_cs_n, pram_sck, pram_dq_oe, busy, done}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        check(pram_cs_n && !pram_sck && !pram_dq_oe && !busy && !done,
              "R1 idle after reset", {pram_cs_n, pram_sck, pram_dq_oe, busy, done}, 5'b10000);
        for (int code = 0; code < 4; code++)
            for (int len = 0; len < 3; len++)
                run_req(1'b1, 8'h38 + 8'(code * 5 + len), 24'h123456 + 24'(code * 4099 + len * 77),
                        len, code, 0, 1'b0);
        for (int code = 0; code < 3; code++) begin
            int dv;
            dv = (code == 1) ? 3 : (code == 2) ? 4 : 2;
            for (int d = 0; d <= LAT + dv + 1; d++)
                run_req(1'b0, 8'hEB, 24'h0A0B00 + 24'(code * 257 + d * 5), 1 + (d % 2), code, d, 1'b0);
        end
        run_req(1'b0, 8'hEB, 24'h00F0F3, 2, 3, LAT, 1'b0);
        run_req(1'b1, 8'h02, 24'h3C5A71, 2, 1, 0, 1'b1);
        run_req(1'b0, 8'hEB, 24'h445566, 1, 2, LAT + 1, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule